// File: doc/BRIEF.md
# Low-Power Bus Turnaround Controller

This block runs the handover of a bidirectional data lane while the lane is in low-power signalling. It works in both directions. When the local end owns the lane and is asked to give it away, it drives a fixed request pattern, holds the bridge level, and then stops driving. When the local end is listening and sees the far end start such a request, it waits a configured interval, drives the bridge level, and closes with a short pattern before it takes ownership.

Every hold time is a whole multiple of one programmable low-power unit interval (called the unit below, counted in clock cycles). The unit has a lower limit set by a parameter. The wait before the listening side drives the bridge is a separate cycle count, and the block clamps it into the window from one to two units. The line pair is encoded as `lineOut[1]` (positive wire) and `lineOut[0]` (negative wire), so stop = `2'b11`, request = `2'b10` and bridge = `2'b00`.

Top module: `lp_turnaround`

## Requirements
- R1: During and after reset with `OWN_AT_RESET`=1, the block owns the lane: `lineOut`=2'b11, `lineOe`=1, `dirTx`=1.
- R2: A `giveReq` sampled high while owning starts the give sequence on the next edge: 2'b11 for U cycles, 2'b10 for U cycles, then 2'b00 for 5·U cycles (one unit followed by the four-unit bridge hold). After that `lineOe` and `dirTx` both drop to 0 on the same edge.
- R3: The unit U equals `lpxCycles`, or `LPX_MIN` when `lpxCycles` is smaller.
- R4: While listening, the block detects a request only when two consecutive samples of `lineIn` are 2'b11 and then 2'b10. `lineOe` rises W+1 rising edges after the edge that captured 2'b10.
- R5: The wait W equals `waitCycles` clamped to the range U to 2·U, inclusive.
- R6: The taking side drives 2'b00 for 5·U cycles, then 2'b10 for U cycles, then 2'b11 for U cycles, all with `dirTx`=0. After that `dirTx` rises while 2'b11 stays driven.
- R7: `giveReq` has no effect while the block does not own the lane.
- R8: `lineIn` has no effect while the block owns the lane. A 2'b10 that is not preceded by 2'b11 does not start a take.
- R9: `lineOe` is low only while listening or waiting. `dirTx`=1 implies `lineOe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| giveReq | input | 1 | Request to hand the lane to the far end |
| lineIn | input | 2 | Sampled low-power line pair {positive, negative} |
| lpxCycles | input | LPX_W | Unit interval length in clock cycles |
| waitCycles | input | LPX_W+1 | Wait before driving the bridge when taking, in cycles |
| lineOut | output | 2 | Driven low-power line pair {positive, negative} |
| lineOe | output | 1 | Line driver enable |
| dirTx | output | 1 | 1 while this end owns the lane |

## Verification
On every cycle, the assertions check how the output edges are ordered. Release happens only out of a bridge that was driven while owning. A take always starts with the bridge and without ownership. Ownership is granted only after a stop level that was already being driven, and the timer load for the wait stays inside the one-to-two-unit window. Only the bench scenarios can show the exact segment lengths for each unit and wait setting (including the floor and both clamp edges), the detection latency, and that stray requests and line levels are ignored.

// File: rtl/lpta_pkg.sv
package lpta_pkg;

  typedef enum logic [3:0] {
    ST_OWN,
    ST_G_STOP,
    ST_G_REQ,
    ST_G_BRIDGE,
    ST_G_GO,
    ST_LISTEN,
    ST_T_WAIT,
    ST_T_GET,
    ST_T_MARK,
    ST_T_STOP
  } taState_e;

  // Which duration the timer loads.
  typedef enum logic [1:0] {
    DUR_LPX,
    DUR_GO4,
    DUR_GET5,
    DUR_WAIT
  } durSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    load;
    durSel_e sel;
  } tmrStrobe_t;

  localparam logic [1:0] LP_STOP   = 2'b11;
  localparam logic [1:0] LP_REQ    = 2'b10;
  localparam logic [1:0] LP_BRIDGE = 2'b00;

endpackage

// File: rtl/lpta_dpath.sv
module lpta_dpath
  import lpta_pkg::*;
#(
  parameter int LPX_W   = 8,
  parameter int LPX_MIN = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPX_W-1:0] lpxCycles,
  input  logic [LPX_W:0]   waitCycles,
  input  logic [1:0]       lineIn,
  input  tmrStrobe_t       ctl,
  output logic             expire,
  output logic             reqSeen
);

  localparam int CNT_W = LPX_W + 3;
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(LPX_MIN);

  logic [CNT_W-1:0] lpxRaw, lpxEff, waitRaw, waitHi, waitEff;
  logic [CNT_W-1:0] dur, remain;
  logic [1:0]       lineQ, lineQPrev;

  // Unit interval with its floor, and the clamped wait.
  always_comb begin
    lpxRaw  = CNT_W'(lpxCycles);
    lpxEff  = (lpxRaw < MIN_V) ? MIN_V : lpxRaw;
    waitRaw = CNT_W'(waitCycles);
    waitHi  = lpxEff << 1;
    if (waitRaw < lpxEff)      waitEff = lpxEff;
    else if (waitRaw > waitHi) waitEff = waitHi;
    else                       waitEff = waitRaw;
  end

  always_comb begin
    unique case (ctl.sel)
      DUR_LPX:  dur = lpxEff;
      DUR_GO4:  dur = lpxEff << 2;
      DUR_GET5: dur = (lpxEff << 2) + lpxEff;
      DUR_WAIT: dur = waitEff;
      default:  dur = lpxEff;
    endcase
  end

  // Countdown: a state loaded with D lasts D cycles.
  always_ff @(posedge clk) begin
    if (!rstN)             remain <= '0;
    else if (ctl.load)     remain <= dur - CNT_W'(1);
    else if (remain != '0) remain <= remain - CNT_W'(1);
  end

  assign expire = (remain == '0);

  // Line sampling and stop-to-request edge detection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ     <= LP_STOP;
      lineQPrev <= LP_STOP;
    end else begin
      lineQ     <= lineIn;
      lineQPrev <= lineQ;
    end
  end

  assign reqSeen = (lineQPrev == LP_STOP) && (lineQ == LP_REQ);

  // R5: a loaded wait always sits in the one-to-two unit window
  a_r5_wait_window: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.sel == DUR_WAIT) |=>
      (remain >= $past(lpxEff) - CNT_W'(1)) &&
      (remain <= ($past(lpxEff) << 1) - CNT_W'(1)));

  // R3: a one-unit load never drops below the floor
  a_r3_lpx_floor: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.sel == DUR_LPX) |=> (remain >= MIN_V - CNT_W'(1)));

endmodule

// File: rtl/lpta_fsm.sv
module lpta_fsm
  import lpta_pkg::*;
#(
  parameter bit OWN_AT_RESET = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       giveReq,
  input  logic       expire,
  input  logic       reqSeen,
  output tmrStrobe_t tmr,
  output logic [1:0] lineOut,
  output logic       lineOe,
  output logic       dirTx
);

  localparam taState_e RESET_ST = OWN_AT_RESET ? ST_OWN : ST_LISTEN;

  taState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= RESET_ST;
    else       state <= nxt;
  end

  // Transitions carry a Mealy load strobe for the next state's duration.
  always_comb begin
    nxt      = state;
    tmr.load = 1'b0;
    tmr.sel  = DUR_LPX;
    unique case (state)
      ST_OWN: if (giveReq) begin
        nxt = ST_G_STOP; tmr.load = 1'b1; tmr.sel = DUR_LPX;
      end
      ST_G_STOP: if (expire) begin
        nxt = ST_G_REQ; tmr.load = 1'b1; tmr.sel = DUR_LPX;
      end
      ST_G_REQ: if (expire) begin
        nxt = ST_G_BRIDGE; tmr.load = 1'b1; tmr.sel = DUR_LPX;
      end
      ST_G_BRIDGE: if (expire) begin
        nxt = ST_G_GO; tmr.load = 1'b1; tmr.sel = DUR_GO4;
      end
      ST_G_GO: if (expire) nxt = ST_LISTEN;
      ST_LISTEN: if (reqSeen) begin
        nxt = ST_T_WAIT; tmr.load = 1'b1; tmr.sel = DUR_WAIT;
      end
      ST_T_WAIT: if (expire) begin
        nxt = ST_T_GET; tmr.load = 1'b1; tmr.sel = DUR_GET5;
      end
      ST_T_GET: if (expire) begin
        nxt = ST_T_MARK; tmr.load = 1'b1; tmr.sel = DUR_LPX;
      end
      ST_T_MARK: if (expire) begin
        nxt = ST_T_STOP; tmr.load = 1'b1; tmr.sel = DUR_LPX;
      end
      ST_T_STOP: if (expire) nxt = ST_OWN;
      default: nxt = RESET_ST;
    endcase
  end

  // Moore output decode.
  always_comb begin
    lineOut = LP_STOP;
    lineOe  = 1'b1;
    dirTx   = 1'b0;
    unique case (state)
      ST_OWN, ST_G_STOP:                     dirTx = 1'b1;
      ST_G_REQ:    begin lineOut = LP_REQ;    dirTx = 1'b1; end
      ST_G_BRIDGE, ST_G_GO:
                   begin lineOut = LP_BRIDGE; dirTx = 1'b1; end
      ST_LISTEN, ST_T_WAIT:                  lineOe = 1'b0;
      ST_T_GET:    lineOut = LP_BRIDGE;
      ST_T_MARK:   lineOut = LP_REQ;
      ST_T_STOP:   lineOut = LP_STOP;
      default:     lineOe = 1'b0;
    endcase
  end

  // R2: the driver lets go only out of a bridge driven while owning
  a_r2_release_after_bridge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineOe) |-> ($past(lineOut) == LP_BRIDGE && $past(dirTx)));

  // R6: a take starts with the bridge level, without ownership
  a_r6_take_starts_bridge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> (lineOut == LP_BRIDGE && !dirTx));

  // R6: ownership follows a stop level that was already driven
  a_r6_own_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dirTx) |-> (lineOe && lineOut == LP_STOP &&
                      $past(lineOut) == LP_STOP && $past(lineOe)));

  // R9: owning always means driving
  a_r9_dir_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    dirTx |-> lineOe);

  // R7: while listening with no request on the line, nothing is driven next
  a_r7_listen_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LISTEN && !reqSeen) |=> !lineOe);

endmodule

// File: rtl/lp_turnaround.sv
module lp_turnaround
  import lpta_pkg::*;
#(
  parameter int LPX_W        = 8,
  parameter int LPX_MIN      = 13,
  parameter bit OWN_AT_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             giveReq,
  input  logic [1:0]       lineIn,
  input  logic [LPX_W-1:0] lpxCycles,
  input  logic [LPX_W:0]   waitCycles,
  output logic [1:0]       lineOut,
  output logic             lineOe,
  output logic             dirTx
);

  tmrStrobe_t tmr;
  logic       expire;
  logic       reqSeen;

  lpta_fsm #(.OWN_AT_RESET(OWN_AT_RESET)) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .giveReq (giveReq),
    .expire  (expire),
    .reqSeen (reqSeen),
    .tmr     (tmr),
    .lineOut (lineOut),
    .lineOe  (lineOe),
    .dirTx   (dirTx)
  );

  lpta_dpath #(.LPX_W(LPX_W), .LPX_MIN(LPX_MIN)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .lpxCycles  (lpxCycles),
    .waitCycles (waitCycles),
    .lineIn     (lineIn),
    .ctl        (tmr),
    .expire     (expire),
    .reqSeen    (reqSeen)
  );

endmodule

// File: tb/tb_lp_turnaround.sv
`timescale 1ns/1ps
module tb_lp_turnaround;

  localparam int LPX_W = 8;
  localparam int NV    = 7;
  // {lpxCycles, waitCycles, expected unit, expected wait}
  localparam int VEC [NV][4] = '{
    '{13, 13, 13, 13},
    '{13, 26, 13, 26},
    '{13, 20, 13, 20},
    '{20,  5, 20, 20},
    '{20, 60, 20, 40},
    '{ 4, 30, 13, 26},
    '{ 0,  0, 13, 13}
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             giveReq;
  logic [1:0]       lineIn;
  logic [LPX_W-1:0] lpxCycles;
  logic [LPX_W:0]   waitCycles;
  logic [1:0]       lineOut;
  logic             lineOe;
  logic             dirTx;

  int  nChecks = 0;
  int  nErr    = 0;
  bit  doneFlag = 1'b0;

  always #2 clk = ~clk;

  lp_turnaround #(.LPX_W(LPX_W), .LPX_MIN(13), .OWN_AT_RESET(1'b1)) dut (
    .clk(clk), .rstN(rstN), .giveReq(giveReq), .lineIn(lineIn),
    .lpxCycles(lpxCycles), .waitCycles(waitCycles),
    .lineOut(lineOut), .lineOe(lineOe), .dirTx(dirTx)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic segLen(input logic [1:0] v, input logic oe, input logic d,
                        output int n);
    n = 0;
    while (lineOut === v && lineOe === oe && dirTx === d && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic doGive(input int u);
    int n;
    giveReq = 1'b1;
    @(negedge clk);
    giveReq = 1'b0;
    segLen(2'b11, 1'b1, 1'b1, n); check("R2 give stop len", n, u);
    segLen(2'b10, 1'b1, 1'b1, n); check("R2 give request len", n, u);
    segLen(2'b00, 1'b1, 1'b1, n); check("R2 give bridge len", n, 5 * u);
    check("R2 released oe", int'(lineOe), 0);
    check("R2 released dir", int'(dirTx), 0);
  endtask

  task automatic doTake(input int u, input int w);
    int n;
    lineIn = 2'b11;
    repeat (3) @(negedge clk);
    lineIn = 2'b10;
    @(negedge clk);
    lineIn = 2'b00;
    segLen(2'b11, 1'b0, 1'b0, n); check("R4 R5 take wait len", n, w + 1);
    segLen(2'b00, 1'b1, 1'b0, n); check("R6 take bridge len", n, 5 * u);
    segLen(2'b10, 1'b1, 1'b0, n); check("R6 take mark len", n, u);
    segLen(2'b11, 1'b1, 1'b0, n); check("R6 take stop len", n, u);
    check("R6 owner dir", int'(dirTx), 1);
    check("R6 owner level", int'(lineOut), 3);
    lineIn = 2'b11;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      nErr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; giveReq = 1'b0; lineIn = 2'b11;
    lpxCycles = 8'd13; waitCycles = 9'd13;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset level", int'(lineOut), 3);
    check("R1 reset oe", int'(lineOe), 1);
    check("R1 reset dir", int'(dirTx), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset dir", int'(dirTx), 1);

    // R8: line activity while owning is ignored
    lineIn = 2'b10;
    repeat (40) @(negedge clk);
    check("R8 owner ignores line oe", int'(lineOe), 1);
    check("R8 owner ignores line dir", int'(dirTx), 1);
    check("R8 owner ignores line level", int'(lineOut), 3);
    lineIn = 2'b11;
    repeat (3) @(negedge clk);

    // Table of unit and wait settings (R2, R3, R4, R5, R6)
    for (int i = 0; i < NV; i++) begin
      lpxCycles  = LPX_W'(VEC[i][0]);
      waitCycles = (LPX_W + 1)'(VEC[i][1]);
      @(negedge clk);
      doGive(VEC[i][2]);
      doTake(VEC[i][2], VEC[i][3]);
      repeat (2) @(negedge clk);
    end

    // R7: giveReq while listening is ignored
    lpxCycles = 8'd13; waitCycles = 9'd15;
    doGive(13);
    giveReq = 1'b1;
    repeat (40) @(negedge clk);
    check("R7 listen ignores give oe", int'(lineOe), 0);
    check("R7 listen ignores give dir", int'(dirTx), 0);
    giveReq = 1'b0;

    // R8: request level without a preceding stop level is ignored
    lineIn = 2'b00;
    repeat (3) @(negedge clk);
    lineIn = 2'b10;
    repeat (60) @(negedge clk);
    check("R8 no stop before request oe", int'(lineOe), 0);
    check("R8 no stop before request dir", int'(dirTx), 0);

    // Recovery with a proper request; giveReq held high the whole time (R7)
    giveReq = 1'b1;
    doTake(13, 15);
    giveReq = 1'b0;

    doneFlag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule